// File: doc/BRIEF.md
# Bridge System Error Reporting Unit

This block decides when the primary side of a two-port bus-to-bus bridge reports a system error. The bridge datapath sends it one-cycle event pulses. These cover data parity errors, target and master aborts on posted writes, target retries on the current posted write, and the level of the secondary-side system error line. The block raises the active-low primary system error signal for one clock per qualifying event. That signal works as an open-drain pull-down enable.

The block keeps three small registers, each written through a simple write port. The control register holds the master system-error enable, the parity-response bits of the two buses and the forward enable for the secondary error line. The cause-enable register holds one enable for each non-parity cause, and all of them are set after reset. The status register holds two sticky bits, which software clears by writing 1. A retry counter of parameterised width counts the target retries of the current posted write. When the counter runs out, it discards the write and raises a one-cycle pulse.

Top module: `serr_report`

## Requirements
- R1: After reset, `pri_serr_n` is 1, `pw_discard` is 0, `status_q` is 0, `ctrl_q` is 0 and `cause_en_q` is 4'hF.
- R2: `pri_serr_n` never goes low while `ctrl_q[0]` (the system-error enable) was 0 in the cycle the event was sampled.
- R3: Every cycle in which `pri_serr_n` is low, `status_q[0]` (signaled) is also 1. A write to address 2 clears each status bit whose data bit is 1. A new setting event in the same cycle wins over the clear.
- R4: On each falling edge of `sec_serr_n`, `status_q[1]` (received) is set. When `ctrl_q[3]` (forward enable) and `cause_en_q[3]` are also set, the edge is a system error event.
- R5: A parity error with `perr_kind` 0 (read), 2 (delayed write) or 3 never causes a system error.
- R6: A posted-write parity error (`perr_kind` 1) going downstream (`perr_upstream`=0) causes a system error only when `perr_on_sec`=1, `perr_on_pri`=0, and both `ctrl_q[1]` and `ctrl_q[2]` (the parity-response bits) are 1.
- R7: A posted-write parity error going upstream causes a system error only when `perr_on_pri`=1, `perr_on_sec`=0, and both parity-response bits are 1.
- R8: `tgt_abort_pw` is a system error event when `cause_en_q[0]` is 1. `mst_abort_pw` is one when `cause_en_q[1]` is 1.
- R9: After 2^RETRY_W `pw_retry` pulses with no `pw_start` or `pw_done` in between, `pw_discard` is high for exactly the one cycle after the final retry. `pw_start` or `pw_done` clears the count.
- R10: A `pw_discard` pulse is a system error event in the next cycle when `cause_en_q[2]` is 1.
- R11: An event sampled at a clock edge drives `pri_serr_n` low for exactly the following cycle. Several events in the same cycle still give one low cycle.
- R12: Address 0 writes `ctrl_q` and address 1 writes `cause_en_q`, each taking the 4-bit write data. Address 3 writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 cause enables, 2 status (write 1 to clear) |
| cfg_wdata | input | 4 | Write data |
| ctrl_q | output | 4 | Control: [0] enable, [1] primary parity response, [2] secondary parity response, [3] forward |
| cause_en_q | output | 4 | Cause enables: [0] target abort, [1] master abort, [2] retry exhaustion, [3] forwarding |
| status_q | output | 2 | Sticky status: [0] signaled, [1] received |
| perr_valid | input | 1 | Data parity error pulse |
| perr_kind | input | 2 | 0 read, 1 posted write, 2 delayed write |
| perr_upstream | input | 1 | 1 when the transaction goes upstream |
| perr_on_pri | input | 1 | Error seen on the primary bus |
| perr_on_sec | input | 1 | Error seen on the secondary bus |
| tgt_abort_pw | input | 1 | Target abort during a posted write |
| mst_abort_pw | input | 1 | Master abort during a posted write |
| pw_start | input | 1 | Posted write begins |
| pw_done | input | 1 | Posted write completes |
| pw_retry | input | 1 | Target retry on the current posted write |
| sec_serr_n | input | 1 | Secondary system error line, active low |
| pw_discard | output | 1 | One-cycle discard pulse on retry exhaustion |
| pri_serr_n | output | 1 | Primary system error, active low, one cycle per event |

## Verification
The bench builds the block with RETRY_W set to 4. A posted write then runs out of retries after 16 pulses instead of about sixteen million. This lets the discard pulse, the event it raises in the following cycle, and the count clear on start or done all come up many times in a short random run. Directed phases first step through each row of the parity-qualification rules with both buses flagged, then the enable gating and the status clear. A long random phase then exercises events that coincide with each other and with register writes.

// File: rtl/serr_report.sv
module serr_report #(
  parameter int RETRY_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [3:0] cfg_wdata,
  output logic [3:0] ctrl_q,
  output logic [3:0] cause_en_q,
  output logic [1:0] status_q,
  input  logic       perr_valid,
  input  logic [1:0] perr_kind,
  input  logic       perr_upstream,
  input  logic       perr_on_pri,
  input  logic       perr_on_sec,
  input  logic       tgt_abort_pw,
  input  logic       mst_abort_pw,
  input  logic       pw_start,
  input  logic       pw_done,
  input  logic       pw_retry,
  input  logic       sec_serr_n,
  output logic       pw_discard,
  output logic       pri_serr_n
);

  localparam logic [1:0] KIND_POSTED = 2'd1;
  localparam logic [RETRY_W-1:0] RETRY_LAST = '1;

  logic [RETRY_W-1:0] retry_cnt;
  logic               sec_prev;
  logic               sec_fall;
  logic               perr_hit;
  logic               serr_event;
  logic [1:0]         stat_clr;

  assign sec_fall = sec_prev & ~sec_serr_n;

  assign perr_hit = perr_valid && perr_kind == KIND_POSTED && ctrl_q[1] && ctrl_q[2] &&
                    (perr_upstream ? (perr_on_pri && !perr_on_sec)
                                   : (perr_on_sec && !perr_on_pri));

  assign serr_event = ctrl_q[0] &&
                      (perr_hit ||
                       (tgt_abort_pw && cause_en_q[0]) ||
                       (mst_abort_pw && cause_en_q[1]) ||
                       (pw_discard   && cause_en_q[2]) ||
                       (sec_fall && ctrl_q[3] && cause_en_q[3]));

  assign stat_clr = (cfg_we && cfg_addr == 2'd2) ? cfg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      cause_en_q <= '1;
      status_q   <= '0;
      sec_prev   <= 1'b1;
      pri_serr_n <= 1'b1;
    end else begin
      if (cfg_we && cfg_addr == 2'd0) ctrl_q <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) cause_en_q <= cfg_wdata;
      status_q   <= (status_q & ~stat_clr) | {sec_fall, serr_event};
      sec_prev   <= sec_serr_n;
      pri_serr_n <= ~serr_event;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retry_cnt  <= '0;
      pw_discard <= 1'b0;
    end else begin
      pw_discard <= 1'b0;
      if (pw_start || pw_done) begin
        retry_cnt <= '0;
      end else if (pw_retry) begin
        if (retry_cnt == RETRY_LAST) begin
          retry_cnt  <= '0;
          pw_discard <= 1'b1;
        end else begin
          retry_cnt <= retry_cnt + 1'b1;
        end
      end
    end
  end

  // R2
  serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_serr_n) |-> $past(ctrl_q[0]));

  // R3
  signaled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> status_q[0]);

  // R4
  received_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_serr_n) |=> status_q[1]);

  // R7
  upstream_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_valid && perr_kind == KIND_POSTED && ctrl_q[2:0] == 3'b111 &&
     perr_upstream && perr_on_pri && !perr_on_sec) |=> !pri_serr_n);

  // R9
  discard_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pw_discard |=> !pw_discard);

  // R10
  discard_serr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_discard && ctrl_q[0] && cause_en_q[2]) |=> !pri_serr_n);

endmodule

// File: tb/serr_report_test.sv
module serr_report_test;
  localparam int W = 4;
  localparam int LAST = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [3:0] cfg_wdata = 0;
  logic [3:0] ctrl_q, cause_en_q;
  logic [1:0] status_q;
  logic perr_valid = 0, perr_upstream = 0, perr_on_pri = 0, perr_on_sec = 0;
  logic [1:0] perr_kind = 0;
  logic tgt_abort_pw = 0, mst_abort_pw = 0, pw_start = 0, pw_done = 0, pw_retry = 0;
  logic sec_serr_n = 1'b1;
  logic pw_discard, pri_serr_n;

  always #2.5 clk = ~clk;

  serr_report #(.RETRY_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .cause_en_q(cause_en_q), .status_q(status_q),
    .perr_valid(perr_valid), .perr_kind(perr_kind), .perr_upstream(perr_upstream),
    .perr_on_pri(perr_on_pri), .perr_on_sec(perr_on_sec),
    .tgt_abort_pw(tgt_abort_pw), .mst_abort_pw(mst_abort_pw),
    .pw_start(pw_start), .pw_done(pw_done), .pw_retry(pw_retry),
    .sec_serr_n(sec_serr_n), .pw_discard(pw_discard), .pri_serr_n(pri_serr_n));

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R11";

  logic [3:0] m_ctrl = 0, m_en = 4'hF;
  logic [1:0] m_stat = 0;
  bit m_discard = 0, m_serr_n = 1, m_prev = 1;
  int m_cnt = 0;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit fall, perr_ok, ev, nd;
    fall = m_prev && !sec_serr_n;
    perr_ok = perr_valid && perr_kind == 2'd1 && m_ctrl[1] && m_ctrl[2] &&
              (perr_upstream ? (perr_on_pri && !perr_on_sec) : (perr_on_sec && !perr_on_pri));
    ev = m_ctrl[0] && (perr_ok || (tgt_abort_pw && m_en[0]) || (mst_abort_pw && m_en[1]) ||
                       (m_discard && m_en[2]) || (fall && m_ctrl[3] && m_en[3]));
    if (cfg_we && cfg_addr == 2) m_stat = m_stat & ~cfg_wdata[1:0];
    if (ev) m_stat[0] = 1;
    if (fall) m_stat[1] = 1;
    if (cfg_we && cfg_addr == 0) m_ctrl = cfg_wdata;
    if (cfg_we && cfg_addr == 1) m_en = cfg_wdata;
    nd = 0;
    if (pw_start || pw_done) m_cnt = 0;
    else if (pw_retry) begin
      if (m_cnt == LAST) begin m_cnt = 0; nd = 1; end
      else m_cnt++;
    end
    m_serr_n = !ev;
    m_prev = sec_serr_n;
    m_discard = nd;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur_req, "pri_serr_n", pri_serr_n, m_serr_n);
    chk("R9", "pw_discard", pw_discard, m_discard);
    chk("R3", "status_q", status_q, m_stat);
    chk("R12", "ctrl_q", ctrl_q, m_ctrl);
    chk("R12", "cause_en_q", cause_en_q, m_en);
    cfg_we = 0; perr_valid = 0; tgt_abort_pw = 0; mst_abort_pw = 0;
    pw_start = 0; pw_done = 0; pw_retry = 0;
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 4'(d); cyc();
  endtask

  task automatic perr(int kind, bit up, bit onp, bit ons);
    perr_valid = 1; perr_kind = 2'(kind); perr_upstream = up;
    perr_on_pri = onp; perr_on_sec = ons; cyc(); cyc();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "pri_serr_n", pri_serr_n, 1);
    chk("R1", "pw_discard", pw_discard, 0);
    chk("R1", "status_q", status_q, 0);
    chk("R1", "ctrl_q", ctrl_q, 0);
    chk("R1", "cause_en_q", cause_en_q, 15);
    rst_n = 1;
    cyc();

    cur_req = "R2"; tgt_abort_pw = 1; cyc(); cyc();
    cur_req = "R12"; wr(3, 15); wr(0, 4'b0111); cyc();
    cur_req = "R6"; perr(1, 0, 0, 1); perr(1, 0, 1, 1); perr(1, 0, 1, 0);
    cur_req = "R7"; perr(1, 1, 1, 0); perr(1, 1, 1, 1); perr(1, 1, 0, 1);
    cur_req = "R5";
    for (int k = 0; k < 4; k++) if (k != 1) begin
      perr(k, 0, 0, 1); perr(k, 1, 1, 0);
    end
    cur_req = "R3"; wr(2, 1); wr(2, 0);
    cur_req = "R6"; wr(0, 4'b0011); perr(1, 0, 0, 1);
    wr(0, 4'b0101); perr(1, 1, 1, 0);
    cur_req = "R8"; wr(0, 1); tgt_abort_pw = 1; cyc(); cyc();
    mst_abort_pw = 1; cyc(); cyc();
    wr(1, 4'b1110); tgt_abort_pw = 1; cyc(); cyc();
    wr(1, 4'b1101); mst_abort_pw = 1; cyc(); cyc();
    cur_req = "R11"; wr(1, 15); tgt_abort_pw = 1; mst_abort_pw = 1; cyc(); cyc();
    cur_req = "R4"; sec_serr_n = 0; cyc(); cyc(); sec_serr_n = 1; cyc();
    wr(0, 4'b1001); sec_serr_n = 0; cyc(); cyc(); sec_serr_n = 1; cyc();
    cur_req = "R3"; wr(2, 3); tgt_abort_pw = 1; cfg_we = 1; cfg_addr = 2; cfg_wdata = 1; cyc(); cyc();
    cur_req = "R9"; pw_start = 1; cyc();
    for (int k = 0; k < 10; k++) begin pw_retry = 1; cyc(); end
    pw_done = 1; cyc();
    cur_req = "R10";
    for (int k = 0; k <= LAST; k++) begin pw_retry = 1; cyc(); end
    cyc(); cyc();
    wr(1, 4'b1011);
    for (int k = 0; k <= LAST; k++) begin pw_retry = 1; cyc(); end
    cyc(); cyc();

    cur_req = "R11";
    for (int n = 0; n < 6000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 4) begin cfg_we = 1; cfg_addr = 2'($urandom); cfg_wdata = 4'($urandom); end
      if (r % 7 == 0) begin
        perr_valid = 1; perr_kind = 2'($urandom); perr_upstream = 1'($urandom);
        perr_on_pri = 1'($urandom); perr_on_sec = 1'($urandom);
      end
      tgt_abort_pw = ($urandom_range(0, 29) == 0);
      mst_abort_pw = ($urandom_range(0, 29) == 0);
      pw_retry = ($urandom_range(0, 9) < 8);
      pw_start = ($urandom_range(0, 59) == 0);
      pw_done = ($urandom_range(0, 79) == 0);
      if ($urandom_range(0, 19) == 0) sec_serr_n = ~sec_serr_n;
      cyc();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule